// File: doc/BRIEF.md
# Ordered Deduplicating Two-Stream Merge

The block takes two token streams, each already in ascending order, and produces one ascending output stream. A value that shows up on both inputs leaves the block only once. Both inputs and the output use a valid/ready handshake. Typical use is to merge a stream of increasing multiples of two with a stream of increasing multiples of three. The result is their ordered union with no repeated values.

The block keeps one head token per input, and each head has a presence flag. It makes no decision until both heads are present. Because of this, the result never depends on how quickly either side delivers tokens. Each transfer on the output frees only the head or heads whose value was emitted. The freed head may be refilled in the same clock edge, so one output per cycle is sustainable. A parameter reverses the merge order for streams sorted in descending order.

Top module: `dedupMerge`

## Requirements
- R1: While reset is asserted, and directly after it, `outValid` is 0 and both `aReady` and `bReady` are 1, since both heads are empty.
- R2: `outValid` stays 0 until a token has been accepted on both inputs. An input whose head is filled and not being consumed shows ready 0, so extra tokens offered there are not taken.
- R3: When the heads differ, `outData` is the smaller head. An output transfer frees only that head: the other input's ready stays 0 in that cycle.
- R4: When the heads are equal, one output carries the value. That transfer frees both heads, and both readies are 1 in that cycle.
- R5: While `outValid` is 1 and `outReady` is 0, both readies are 0, and in the next cycle `outValid` is still 1 with `outData` unchanged.
- R6: With both inputs always valid and the output always ready, an output of N tokens completes in N+1 cycles counted from the first offered tokens.
- R7: Comparison is unsigned over `DATA_W` bits, so 16'h7FFF sorts before 16'h8000 and 16'h8000 sorts before 16'hFFFF.
- R8: For two strictly ascending input streams, the output sequence is their ordered union with every duplicate value removed. This holds under any pattern of input gaps and output stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| aValid | input | 1 | Stream A offers a token |
| aReady | output | 1 | Stream A token accepted this cycle when valid |
| aData | input | DATA_W | Stream A token value |
| bValid | input | 1 | Stream B offers a token |
| bReady | output | 1 | Stream B token accepted this cycle when valid |
| bData | input | DATA_W | Stream B token value |
| outValid | output | 1 | Merged token available |
| outReady | input | 1 | Consumer takes the merged token |
| outData | output | DATA_W | Merged token value |

## Verification
The checker watches the cycle-level handshake rules on every clock. These cover the stall hold with its blocked readies, the single-head release on unequal heads, the dual release on equal heads, and ready being high whenever a head is empty. Other properties need whole scenarios from the bench. The ordered duplicate-free sequence under random gaps and stalls is one of them. The others are the unsigned ordering near the top bit, the N+1 cycle throughput figure, and the refusal to emit while only one head is filled.

// File: rtl/dedupMergePkg.sv
package dedupMergePkg;
  typedef struct packed {
    logic loadA;
    logic loadB;
    logic pickB;
  } mergeStrobe_t;
endpackage

// File: rtl/dedupMergeCtrl.sv
module dedupMergeCtrl
  import dedupMergePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         aValid,
  input  logic         bValid,
  input  logic         outReady,
  input  logic         aFirst,
  input  logic         bFirst,
  output mergeStrobe_t strobe,
  output logic         aReady,
  output logic         bReady,
  output logic         outValid,
  output logic         validA,
  output logic         validB
);
  logic fire, takeA, takeB;

  always_comb begin
    outValid     = validA && validB;
    fire         = outValid && outReady;
    takeA        = fire && !bFirst;
    takeB        = fire && !aFirst;
    aReady       = !validA || takeA;
    bReady       = !validB || takeB;
    strobe.loadA = aValid && aReady;
    strobe.loadB = bValid && bReady;
    strobe.pickB = bFirst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validA <= 1'b0;
      validB <= 1'b0;
    end else begin
      if (strobe.loadA)  validA <= 1'b1;
      else if (takeA)    validA <= 1'b0;
      if (strobe.loadB)  validB <= 1'b1;
      else if (takeB)    validB <= 1'b0;
    end
  end
endmodule

// File: rtl/dedupMergeData.sv
module dedupMergeData
  import dedupMergePkg::*;
#(
  parameter int DATA_W  = 16,
  parameter bit DESCEND = 1'b0
) (
  input  logic              clk,
  input  logic [DATA_W-1:0] aData,
  input  logic [DATA_W-1:0] bData,
  input  mergeStrobe_t      strobe,
  output logic [DATA_W-1:0] headA,
  output logic [DATA_W-1:0] headB,
  output logic [DATA_W-1:0] outData,
  output logic              aFirst,
  output logic              bFirst
);
  always_ff @(posedge clk) begin
    if (strobe.loadA) headA <= aData;
    if (strobe.loadB) headB <= bData;
  end

  generate
    if (DESCEND) begin : gDesc
      assign aFirst = headA > headB;
      assign bFirst = headB > headA;
    end else begin : gAsc
      assign aFirst = headA < headB;
      assign bFirst = headB < headA;
    end
  endgenerate

  assign outData = strobe.pickB ? headB : headA;
endmodule

// File: rtl/dedupMerge.sv
module dedupMerge
  import dedupMergePkg::*;
#(
  parameter int DATA_W  = 16,
  parameter bit DESCEND = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aValid,
  output logic              aReady,
  input  logic [DATA_W-1:0] aData,
  input  logic              bValid,
  output logic              bReady,
  input  logic [DATA_W-1:0] bData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);
  mergeStrobe_t      strobe;
  logic              aFirst, bFirst, validA, validB;
  logic [DATA_W-1:0] headA, headB;

  dedupMergeCtrl ctrl (
    .clk(clk), .rstN(rstN), .aValid(aValid), .bValid(bValid),
    .outReady(outReady), .aFirst(aFirst), .bFirst(bFirst),
    .strobe(strobe), .aReady(aReady), .bReady(bReady),
    .outValid(outValid), .validA(validA), .validB(validB)
  );

  dedupMergeData #(.DATA_W(DATA_W), .DESCEND(DESCEND)) data (
    .clk(clk), .aData(aData), .bData(bData), .strobe(strobe),
    .headA(headA), .headB(headB), .outData(outData),
    .aFirst(aFirst), .bFirst(bFirst)
  );
endmodule

// File: rtl/dedupMergeChecker.sv
module dedupMergeChecker #(
  parameter int DATA_W  = 16,
  parameter bit DESCEND = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              aReady,
  input logic              bReady,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic [DATA_W-1:0] headA,
  input logic [DATA_W-1:0] headB,
  input logic              validA,
  input logic              validB
);
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  a_r5_stall_block: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !aReady && !bReady);

  a_r4_equal_frees_both: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && headA == headB |-> aReady && bReady);

  a_r3_single_release: assert property (@(posedge clk) disable iff (!rstN)
    !DESCEND && outValid && outReady && headA < headB |-> aReady && !bReady);

  a_r2_empty_ready: assert property (@(posedge clk) disable iff (!rstN)
    (!validA |-> aReady) and (!validB |-> bReady));
endmodule

bind dedupMerge dedupMergeChecker #(.DATA_W(DATA_W), .DESCEND(DESCEND)) chk (
  .clk(clk), .rstN(rstN), .aReady(aReady), .bReady(bReady),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .headA(headA), .headB(headB), .validA(validA), .validB(validB)
);

// File: tb/dedupMerge_test.sv
module dedupMerge_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        aValid = 1'b0, bValid = 1'b0, outReady = 1'b0;
  logic [15:0] aData = '0, bData = '0;
  logic        aReady, bReady, outValid;
  logic [15:0] outData;

  int checks = 0, fails = 0;
  logic [15:0] strA [0:63];
  logic [15:0] strB [0:63];
  logic [15:0] expQ [0:127];
  int lenA, lenB, expN;

  always #5 clk = ~clk;

  dedupMerge uut (
    .clk(clk), .rstN(rstN), .aValid(aValid), .aReady(aReady), .aData(aData),
    .bValid(bValid), .bReady(bReady), .bData(bData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void buildExpected();
    int i = 0, j = 0;
    expN = 0;
    while (i < lenA || j < lenB) begin
      if (j >= lenB || (i < lenA && strA[i] < strB[j])) begin
        expQ[expN] = strA[i]; i++;
      end else if (i >= lenA || strB[j] < strA[i]) begin
        expQ[expN] = strB[j]; j++;
      end else begin
        expQ[expN] = strA[i]; i++; j++;
      end
      expN++;
    end
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; aValid = 0; bValid = 0; outReady = 0;
    repeat (2) @(negedge clk);
    #1;
    check(!outValid && aReady && bReady, "R1", {outValid, aReady, bReady}, 3'b011);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!outValid && aReady && bReady, "R1", {outValid, aReady, bReady}, 3'b011);
  endtask

  task automatic runMerge(input int gapPct, input int stallPct, input string req, output int cycles);
    int ia = 0, ib = 0, io = 0, cyc = 0;
    bit prevStall = 0;
    logic [15:0] holdData = '0;
    bit fa, fb;
    buildExpected();
    while (io < expN && cyc < 5000) begin
      @(negedge clk);
      aValid = (ia < lenA) && ($urandom_range(99) >= gapPct);
      aData = aValid ? strA[ia] : 16'h0;
      bValid = (ib < lenB) && ($urandom_range(99) >= gapPct);
      bData = bValid ? strB[ib] : 16'h0;
      outReady = ($urandom_range(99) >= stallPct);
      #1;
      if (prevStall) check(outValid && outData == holdData, "R5", outData, holdData);
      prevStall = outValid && !outReady;
      holdData = outData;
      fa = aValid && aReady;
      fb = bValid && bReady;
      if (outValid && outReady) begin
        check(outData == expQ[io], req, outData, expQ[io]);
        io++;
      end
      @(posedge clk);
      if (fa) ia++;
      if (fb) ib++;
      cyc++;
    end
    if (cyc >= 5000) check(1'b0, "watchdog", io, expN);
    @(negedge clk);
    aValid = 0; bValid = 0;
    #1;
    check(!outValid && aReady && bReady, "R4", {outValid, aReady, bReady}, 3'b011);
    cycles = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    void'($urandom(32'd4711));
    doReset();

    // R2 / R3 directed: only A offered first
    @(negedge clk);
    aValid = 1; aData = 16'd5; outReady = 1;
    @(negedge clk);
    aData = 16'd9;
    #1;
    check(!outValid && !aReady, "R2", {outValid, aReady}, 2'b00);
    @(negedge clk);
    #1;
    check(!outValid, "R2", outValid, 0);
    aValid = 0; bValid = 1; bData = 16'd7;
    @(negedge clk);
    bValid = 0;
    #1;
    check(outValid && outData == 16'd5, "R3", outData, 16'd5);
    check(aReady && !bReady, "R3", {aReady, bReady}, 2'b10);
    doReset();

    // R8: multiples of 2 and 3, random gaps and stalls
    lenA = 21; lenB = 15;
    for (int k = 0; k < 20; k++) strA[k] = 16'(2 * (k + 1));
    for (int k = 0; k < 14; k++) strB[k] = 16'(3 * (k + 1));
    strA[20] = 16'hFFFF; strB[14] = 16'hFFFF;
    runMerge(30, 30, "R8", cyc);

    // R6: full throughput on the same streams
    doReset();
    runMerge(0, 0, "R8", cyc);
    check(cyc == expN + 1, "R6", cyc, expN + 1);

    // R7: unsigned ordering around the top bit
    doReset();
    lenA = 4; strA[0] = 16'h0001; strA[1] = 16'h7FFF; strA[2] = 16'h8000; strA[3] = 16'hFFFF;
    lenB = 3; strB[0] = 16'h8000; strB[1] = 16'h8001; strB[2] = 16'hFFFF;
    runMerge(20, 20, "R7", cyc);

    // R3 / R4 / R8: random ascending streams with collisions
    for (int it = 0; it < 6; it++) begin
      int v;
      doReset();
      lenA = 10 + $urandom_range(40); lenB = 10 + $urandom_range(40);
      v = 0;
      for (int k = 0; k < lenA - 1; k++) begin v += 1 + $urandom_range(2); strA[k] = 16'(v); end
      v = 0;
      for (int k = 0; k < lenB - 1; k++) begin v += 1 + $urandom_range(2); strB[k] = 16'(v); end
      strA[lenA-1] = 16'hFFFF; strB[lenB-1] = 16'hFFFF;
      runMerge(it * 10, 50 - it * 8, "R3", cyc);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule